// File: doc/BRIEF.md
# Revertive Reference Source Selector

This controller watches a group of candidate timing references and keeps exactly one of them selected as the active reference. Each candidate carries a priority value, a fail indication and a phase alarm. A candidate is usable only when it is not failed and carries no phase alarm. The controller then picks the usable candidate with the best priority. It can do this in revertive fashion, where it always moves to the best usable candidate. It can also work non-revertively, where it stays on the current candidate until that candidate becomes unusable.

Phase alarms are latched per source. They can be cleared by an explicit clear strobe. If the timeout mode is on, they also clear by themselves after a fixed number of one-second ticks. An external frame-sync enable output is gated by an 8-bit mode byte. In auto-disarm mode this enable drops at the first source switch and stays low until software writes the enable bit to 1 again. Each change of selection is marked by a single-cycle switch event. When no candidate is usable, a no-source flag is raised and the last selection is kept.

Top module: `ref_selector`

## Requirements
- R1: After reset the mode byte is 8'hCA. Bit 7 is sync auto-disarm, bit 6 is alarm timeout enable, bit 3 is sync enable and bit 0 is revertive mode (1 = revertive); bits 4 and 1 are unused. While reset is held, `sel_idx` = 0, `sel_switch` = 0, `no_src` = 1, `sync_en` = 1 and all phase alarms are 0.
- R2: A source whose `src_fail` bit is 1, or whose phase alarm is 1, is never selected.
- R3: In revertive mode the selection moves, one clock after the inputs settle, to the usable source with the numerically smallest priority value (source i at `src_prio[i*PRIO_W +: PRIO_W]`). On a tie, the lowest index wins.
- R4: In non-revertive mode the current source is kept while it is usable, even when a better source is usable. When it becomes unusable, the selection moves to the best usable source per R3.
- R5: When no source is usable, `no_src` is 1 one clock later, `sel_idx` holds its value and no switch event is produced.
- R6: `sel_switch` is high for exactly the one cycle in which `sel_idx` shows a new value, and low otherwise.
- R7: A pulse on `alarm_set[i]` sets phase alarm i on the next clock. A pulse on `alarm_clr[i]` clears it. With mode bit 6 = 0, ticks never clear it.
- R8: With mode bit 6 = 1, phase alarm i clears on the 128th `sec_tick` pulse counted after it was last set.
- R9: When mode bit 3 is 0, `sync_en` is 0.
- R10: When mode bit 7 is 0, `sync_en` equals mode bit 3, whatever source switches happen.
- R11: When mode bits 7 and 3 are 1, `sync_en` drops to 0 in the cycle the switch event is shown. It stays 0 until a mode write with bit 3 = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Mode byte write strobe |
| cfg_wdata | input | 8 | Mode byte write data |
| src_fail | input | N_SRC | Per-source failure indication |
| alarm_set | input | N_SRC | Per-source phase alarm set pulse |
| alarm_clr | input | N_SRC | Per-source phase alarm software clear pulse |
| src_prio | input | N_SRC*PRIO_W | Per-source priority values, smaller is better |
| sec_tick | input | 1 | One-cycle pulse once per second |
| sel_idx | output | IDX_W | Index of the selected source |
| sel_switch | output | 1 | One-cycle pulse on a selection change |
| no_src | output | 1 | No usable source exists |
| sync_en | output | 1 | External frame-sync enable |
| phase_alarm | output | N_SRC | Current per-source phase alarm state |

## Verification
The bench keeps the selector parked on a worse source in non-revertive mode. A design that reverts anyway would move to the better source. It ties priorities so that a wrong comparison (using <= instead of <) would pick the higher index. It removes every source at once to catch a design that switches to an unusable index or pulses the switch event. Phase alarms are ticked to one short of the timeout and then to the timeout exactly, which exposes an off-by-one count. With timeout disabled, the bench checks that a long run of ticks does not clear an alarm. Sync enable is checked across switches with auto-disarm both on and off, and after a rewrite. A design that ignored the disarm, or never re-armed, shows the wrong level.

// File: rtl/refsel_pkg.sv
package refsel_pkg;
    localparam int unsigned MODE_W     = 8;
    localparam int unsigned BIT_AUTO   = 7;
    localparam int unsigned BIT_TMO    = 6;
    localparam int unsigned BIT_SYNC   = 3;
    localparam int unsigned BIT_REVERT = 0;
    localparam logic [MODE_W-1:0] MODE_RST = 8'hCA;

    typedef struct packed {
        logic auto_dis;
        logic tmo_en;
        logic sync_on;
        logic revert;
    } mode_t;
endpackage

// File: rtl/refsel_cfg.sv
module refsel_cfg
    import refsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [MODE_W-1:0] wdata,
    output logic [MODE_W-1:0] mode_byte,
    output mode_t             mode,
    output logic              arm_set,
    output logic              arm_clr
);
    logic [MODE_W-1:0] mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (we) begin
            mode_d = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
        end else begin
            mode_q <= mode_d;
        end
    end

    assign mode_byte     = mode_q;
    assign mode.auto_dis = mode_q[BIT_AUTO];
    assign mode.tmo_en   = mode_q[BIT_TMO];
    assign mode.sync_on  = mode_q[BIT_SYNC];
    assign mode.revert   = mode_q[BIT_REVERT];
    assign arm_set       = we &  wdata[BIT_SYNC];
    assign arm_clr       = we & ~wdata[BIT_SYNC];
endmodule

// File: rtl/refsel_alarm.sv
module refsel_alarm #(
    parameter int unsigned TMO_TICKS = 128,
    localparam int unsigned CNT_W    = (TMO_TICKS > 1) ? $clog2(TMO_TICKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    input  logic tick,
    input  logic tmo_en,
    output logic alarm
);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_TICKS - 1);

    typedef struct packed {
        logic             on;
        logic [CNT_W-1:0] cnt;
    } alm_t;

    alm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (set) begin
            st_d.on  = 1'b1;
            st_d.cnt = '0;
        end else if (clr) begin
            st_d.on  = 1'b0;
            st_d.cnt = '0;
        end else if (st_q.on && tmo_en && tick) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.on  = 1'b0;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm = st_q.on;
endmodule

// File: rtl/refsel_pick.sv
module refsel_pick #(
    parameter int unsigned N_SRC  = 4,
    parameter int unsigned PRIO_W = 4,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]        elig,
    input  logic [N_SRC*PRIO_W-1:0] prio,
    output logic [IDX_W-1:0]        best_idx,
    output logic                    any_ok
);
    logic [PRIO_W-1:0] best_p;

    always_comb begin
        best_idx = '0;
        best_p   = '1;
        any_ok   = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (elig[i] && (!any_ok || (prio[i*PRIO_W +: PRIO_W] < best_p))) begin
                best_idx = IDX_W'(i);
                best_p   = prio[i*PRIO_W +: PRIO_W];
                any_ok   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ref_selector.sv
module ref_selector
    import refsel_pkg::*;
#(
    parameter int unsigned N_SRC     = 4,
    parameter int unsigned PRIO_W    = 4,
    parameter int unsigned TMO_TICKS = 128,
    localparam int unsigned IDX_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [7:0]              cfg_wdata,
    input  logic [N_SRC-1:0]        src_fail,
    input  logic [N_SRC-1:0]        alarm_set,
    input  logic [N_SRC-1:0]        alarm_clr,
    input  logic [N_SRC*PRIO_W-1:0] src_prio,
    input  logic                    sec_tick,
    output logic [IDX_W-1:0]        sel_idx,
    output logic                    sel_switch,
    output logic                    no_src,
    output logic                    sync_en,
    output logic [N_SRC-1:0]        phase_alarm
);
    typedef struct packed {
        logic [IDX_W-1:0] sel;
        logic             sw;
        logic             none;
        logic             arm;
    } sel_st_t;

    logic [MODE_W-1:0] mode_byte;
    mode_t             mode;
    logic              arm_set, arm_clr;
    logic [N_SRC-1:0]  elig;
    logic [IDX_W-1:0]  best_idx, tgt;
    logic              any_ok;
    sel_st_t           st_d, st_q;

    refsel_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (cfg_we),
        .wdata     (cfg_wdata),
        .mode_byte (mode_byte),
        .mode      (mode),
        .arm_set   (arm_set),
        .arm_clr   (arm_clr)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_alarm
        refsel_alarm #(.TMO_TICKS(TMO_TICKS)) u_alarm (
            .clk    (clk),
            .rst_n  (rst_n),
            .set    (alarm_set[g]),
            .clr    (alarm_clr[g]),
            .tick   (sec_tick),
            .tmo_en (mode.tmo_en),
            .alarm  (phase_alarm[g])
        );
    end

    assign elig = ~src_fail & ~phase_alarm;

    refsel_pick #(.N_SRC(N_SRC), .PRIO_W(PRIO_W)) u_pick (
        .elig     (elig),
        .prio     (src_prio),
        .best_idx (best_idx),
        .any_ok   (any_ok)
    );

    always_comb begin
        st_d      = st_q;
        st_d.sw   = 1'b0;
        st_d.none = ~any_ok;
        tgt       = st_q.sel;
        if (any_ok && (mode.revert || !elig[st_q.sel])) begin
            tgt = best_idx;
        end
        if (tgt != st_q.sel) begin
            st_d.sel = tgt;
            st_d.sw  = 1'b1;
        end
        if (st_d.sw && mode.auto_dis) begin
            st_d.arm = 1'b0;
        end
        if (arm_set) begin
            st_d.arm = 1'b1;
        end else if (arm_clr) begin
            st_d.arm = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel  <= '0;
            st_q.sw   <= 1'b0;
            st_q.none <= 1'b1;
            st_q.arm  <= MODE_RST[BIT_SYNC];
        end else begin
            st_q <= st_d;
        end
    end

    assign sel_idx    = st_q.sel;
    assign sel_switch = st_q.sw;
    assign no_src     = st_q.none;
    assign sync_en    = mode.sync_on & (st_q.arm | ~mode.auto_dis);
endmodule

// File: rtl/refsel_chk.sv
module refsel_chk #(
    parameter int unsigned N_SRC  = 4,
    localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [7:0]       cfg_wdata,
    input logic [N_SRC-1:0] src_fail,
    input logic [N_SRC-1:0] alarm_clr,
    input logic [N_SRC-1:0] phase_alarm,
    input logic [IDX_W-1:0] sel_idx,
    input logic             sel_switch,
    input logic             no_src,
    input logic             sync_en,
    input logic [7:0]       mode_byte
);
    logic [N_SRC-1:0] usable_prev;

    always_ff @(posedge clk) begin
        usable_prev <= ~src_fail & ~phase_alarm;
    end

    AST_SEL_USABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !no_src |-> usable_prev[sel_idx]); // R2

    AST_NOSRC_NO_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        no_src |-> !sel_switch); // R5

    AST_SWITCH_MEANS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        sel_switch |-> (sel_idx != $past(sel_idx))); // R6

    AST_CHANGE_MEANS_SWITCH: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_switch |-> $stable(sel_idx)); // R6

    AST_ALARM_NO_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_byte[6] && !cfg_we) |=>
        ((($past(phase_alarm) & ~$past(alarm_clr)) & ~phase_alarm) == '0)); // R7

    AST_SYNC_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !cfg_wdata[3]) |=> !sync_en); // R9

    AST_AUTO_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_switch && mode_byte[7] && !$past(cfg_we)) |-> !sync_en); // R11
endmodule

bind ref_selector refsel_chk #(.N_SRC(N_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .src_fail    (src_fail),
    .alarm_clr   (alarm_clr),
    .phase_alarm (phase_alarm),
    .sel_idx     (sel_idx),
    .sel_switch  (sel_switch),
    .no_src      (no_src),
    .sync_en     (sync_en),
    .mode_byte   (mode_byte)
);

// File: tb/ref_selector_tb.sv
module ref_selector_tb;
    localparam int N_SRC  = 4;
    localparam int PRIO_W = 4;
    localparam int IDX_W  = 2;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    cfg_we = 1'b0;
    logic [7:0]              cfg_wdata = '0;
    logic [N_SRC-1:0]        src_fail = '0;
    logic [N_SRC-1:0]        alarm_set = '0;
    logic [N_SRC-1:0]        alarm_clr = '0;
    logic [N_SRC*PRIO_W-1:0] src_prio = 16'h7224;
    logic                    sec_tick = 1'b0;
    logic [IDX_W-1:0]        sel_idx;
    logic                    sel_switch;
    logic                    no_src;
    logic                    sync_en;
    logic [N_SRC-1:0]        phase_alarm;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    ref_selector #(.N_SRC(N_SRC), .PRIO_W(PRIO_W), .TMO_TICKS(128)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_we      (cfg_we),
        .cfg_wdata   (cfg_wdata),
        .src_fail    (src_fail),
        .alarm_set   (alarm_set),
        .alarm_clr   (alarm_clr),
        .src_prio    (src_prio),
        .sec_tick    (sec_tick),
        .sel_idx     (sel_idx),
        .sel_switch  (sel_switch),
        .no_src      (no_src),
        .sync_en     (sync_en),
        .phase_alarm (phase_alarm)
    );

    // {fail[3:0], prio {p3,p2,p1,p0}, expected sel, expected no_src}
    localparam logic [22:0] VEC [8] = '{
        {4'b0000, 16'h3333, 2'd0, 1'b0},
        {4'b0000, 16'h9115, 2'd1, 1'b0},
        {4'b0010, 16'h9115, 2'd2, 1'b0},
        {4'b0110, 16'h9115, 2'd0, 1'b0},
        {4'b1111, 16'h9115, 2'd0, 1'b1},
        {4'b0001, 16'h2660, 2'd3, 1'b0},
        {4'b0000, 16'hFEFF, 2'd2, 1'b0},
        {4'b1000, 16'h0FFF, 2'd0, 1'b0}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_mode(input logic [7:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            sec_tick = 1'b1;
            step(1);
            sec_tick = 1'b0;
            step(1);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #100000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(3);
        // R1 reset state
        chk("R1 sel", sel_idx, 0);
        chk("R1 switch", sel_switch, 0);
        chk("R1 no_src", no_src, 1);
        chk("R1 sync_en", sync_en, 1);
        chk("R1 alarms", phase_alarm, 0);
        rst_n = 1'b1;
        step(3);
        // R4 non-revertive default: stays on src0 though src1 is better
        chk("R4 hold worse", sel_idx, 0);
        chk("R5 no_src clear", no_src, 0);
        src_fail = 4'b0001;
        step(1);
        chk("R4 move on fail", sel_idx, 1);
        chk("R6 pulse high", sel_switch, 1);
        chk("R11 disarm", sync_en, 0);
        step(1);
        chk("R6 pulse low", sel_switch, 0);
        src_fail = '0;
        step(2);
        chk("R11 stays low", sync_en, 0);
        wr_mode(8'hCA);
        chk("R11 rearm", sync_en, 1);

        // R3 revertive with auto-disarm
        wr_mode(8'hCB);
        step(2);
        chk("R3 best", sel_idx, 1);
        src_fail = 4'b0010;
        step(1);
        chk("R3 tie low idx", sel_idx, 2);
        chk("R11 disarm rev", sync_en, 0);
        src_fail = '0;
        step(1);
        chk("R3 revert", sel_idx, 1);
        chk("R6 revert pulse", sel_switch, 1);

        // R10 auto-disarm off
        wr_mode(8'h4B);
        chk("R10 follow", sync_en, 1);
        src_fail = 4'b0010;
        step(1);
        chk("R10 switched", sel_idx, 2);
        chk("R10 kept", sync_en, 1);
        src_fail = '0;
        step(2);
        chk("R10 back", sel_idx, 1);

        // R9 sync bit off
        wr_mode(8'h43);
        chk("R9 off", sync_en, 0);

        // R5 nothing usable
        src_fail = 4'b1111;
        step(1);
        chk("R5 flag", no_src, 1);
        chk("R5 held", sel_idx, 1);
        chk("R5 no pulse", sel_switch, 0);
        step(1);
        chk("R5 still held", sel_idx, 1);
        src_fail = '0;
        step(2);
        chk("R5 flag off", no_src, 0);

        // R8 timeout (mode 0x43: timeout on, revertive)
        alarm_set = 4'b0010;
        step(1);
        alarm_set = '0;
        chk("R8 alarm set", phase_alarm, 4'b0010);
        step(1);
        chk("R2 alarm excludes", sel_idx, 2);
        ticks(127);
        chk("R8 before timeout", phase_alarm, 4'b0010);
        ticks(1);
        chk("R8 timed out", phase_alarm, 0);
        chk("R3 after clear", sel_idx, 1);

        // R7 timeout off: only software clear
        wr_mode(8'h03);
        alarm_set = 4'b0100;
        step(1);
        alarm_set = '0;
        chk("R7 set", phase_alarm, 4'b0100);
        ticks(200);
        chk("R7 survives ticks", phase_alarm, 4'b0100);
        alarm_clr = 4'b0100;
        step(1);
        alarm_clr = '0;
        chk("R7 sw clear", phase_alarm, 0);

        // R3 / R2 / R5 vector table, revertive
        foreach (VEC[k]) begin
            src_fail = VEC[k][22:19];
            src_prio = VEC[k][18:3];
            step(2);
            chk($sformatf("R3 vec%0d sel", k), sel_idx, int'(VEC[k][2:1]));
            chk($sformatf("R5 vec%0d no_src", k), no_src, int'(VEC[k][0]));
        end

        finish_run();
    end
endmodule